// File: doc/BRIEF.md
# Mixed-Sign Integer Multiplier Core

This block forms the product of two 16-bit integers in one clock. Each operand has its own signedness flag, so a single request can be signed times signed, unsigned times unsigned, or signed times unsigned in either order. A width select switches to byte mode. In byte mode only the low eight bits of each operand take part, and the upper operand bits have no effect.

Both operands first go through a per-operand extender that widens them to 17 bits. A signed operand is widened with its own top bit, taken from bit 15 in word mode and bit 7 in byte mode. An unsigned operand is widened with zeros. One 17x17 signed array then serves every mode. The low 32 bits of the array output are the exact two's-complement product for every legal combination.

The result is captured in a register when the start strobe is sampled high, and a valid flag accompanies it in the following cycle. A host issues one request per cycle at most. It may issue back-to-back requests.

Top module: `mulx_core`

## Requirements
- R1: While reset is high, and in the first cycle after it, product_o is 0 and valid_o is 0.
- R2: valid_o is 1 in exactly the cycle after each clock edge that samples start_i high, and 0 otherwise. Starts in consecutive cycles give valid in consecutive cycles.
- R3: product_o keeps its value across every clock edge that samples start_i low, whatever the operands, flags and width select do.
- R4: With narrow_i=0 and both signed flags 0, product_o is the unsigned 32-bit product of a_i and b_i (for example, 0xFFFF times 0xFFFF gives 0xFFFE0001).
- R5: With narrow_i=0 and both signed flags 1, bit 15 is the sign and product_o is the 32-bit two's-complement product (for example, 0x8000 times 0x8000 gives 0x40000000).
- R6: With narrow_i=0 and exactly one signed flag set, the flagged operand is two's complement and the other is unsigned. For example, a signed 0x8000 times an unsigned 0xFFFF gives 0x80008000, and the mirrored case works the same way.
- R7: With narrow_i=1, bits 15:8 of a_i and b_i have no effect on product_o.
- R8: With narrow_i=1, the byte product appears as a 32-bit value. It is zero-extended when both flags are 0, and sign-extended from bit 15 otherwise. For example, signed 0x80 times unsigned 0xFF gives 0xFFFF8080, and unsigned 0xFF times 0xFF gives 0x0000FE01.
- R9: In byte mode a signed flag makes bit 7 the sign. In word mode bit 15 is the sign. For example, a_i=0x0080 is -128 as a signed byte but +128 as a signed word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, sampled on the rising edge |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| a_signed_i | input | 1 | 1 = a_i is two's complement |
| b_signed_i | input | 1 | 1 = b_i is two's complement |
| narrow_i | input | 1 | 1 = byte mode (low 8 bits of each operand) |
| product_o | output | 32 | Registered product |
| valid_o | output | 1 | High for one cycle after each sampled start |

## Verification
The only state in this block is the result register and the valid flag. A wrong extension bit or width choice therefore appears at product_o in the cycle right after the request that triggered it. It shows most clearly at the operand extremes: 0x8000, 0xFFFF, 0x80 and 0xFF in each sign combination. A register that loads when it should not, or a valid flag that is stretched or lost, shows one cycle after a start or after an idle edge. For this reason each request is followed by an idle cycle with scrambled inputs.

// File: rtl/mulx_pkg.sv
package mulx_pkg;
  typedef struct packed {
    logic a_signed;
    logic b_signed;
    logic narrow;
  } mulx_mode_t;
endpackage

// File: rtl/mulx_operand_ext.sv
module mulx_operand_ext #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic                     signed_i,
  input  logic                     narrow_i,
  input  logic [DATA_W-1:0]        op_i,
  output logic signed [DATA_W:0]   ext_o
);
  localparam int EXT_W = DATA_W + 1;
  localparam int PAD_W = EXT_W - NARROW_W;

  logic fill;

  always_comb begin
    if (narrow_i) begin
      fill  = signed_i & op_i[NARROW_W-1];
      ext_o = {{PAD_W{fill}}, op_i[NARROW_W-1:0]};
    end else begin
      fill  = signed_i & op_i[DATA_W-1];
      ext_o = {fill, op_i};
    end
  end

  // R8
  always_comb begin
    narrow_unsigned_pad_chk: assert (!(narrow_i && !signed_i) || ext_o[EXT_W-1:NARROW_W] == '0);
  end
endmodule

// File: rtl/mulx_array.sv
module mulx_array #(
  parameter int EXT_W = 17,
  parameter int OUT_W = 32
) (
  input  logic signed [EXT_W-1:0] a_i,
  input  logic signed [EXT_W-1:0] b_i,
  output logic        [OUT_W-1:0] prod_o
);
  localparam int PROD_W = 2 * EXT_W;

  logic signed [PROD_W-1:0] full;

  always_comb begin
    full   = a_i * b_i;
    prod_o = full[OUT_W-1:0];
  end

  // R4
  always_comb begin
    discard_fit_chk: assert (full[PROD_W-1] == full[PROD_W-2]);
  end
endmodule

// File: rtl/mulx_result_reg.sv
module mulx_result_reg #(
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [OUT_W-1:0] prod_i,
  output logic [OUT_W-1:0] product_o,
  output logic             valid_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      product_o <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) product_o <= prod_i;
    end
  end

  // R2
  valid_after_start_chk: assert property (@(posedge clk) disable iff (rst) load_i |=> valid_o);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst) !load_i |=> !valid_o);
  // R3
  product_hold_chk: assert property (@(posedge clk) disable iff (rst) !load_i |=> $stable(product_o));
endmodule

// File: rtl/mulx_core.sv
module mulx_core
  import mulx_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic                a_signed_i,
  input  logic                b_signed_i,
  input  logic                narrow_i,
  output logic [2*DATA_W-1:0] product_o,
  output logic                valid_o
);
  localparam int EXT_W  = DATA_W + 1;
  localparam int OUT_W  = 2 * DATA_W;
  localparam int HALF_W = 2 * NARROW_W;

  mulx_mode_t mode;
  logic signed [EXT_W-1:0] a_ext, b_ext;
  logic [OUT_W-1:0] prod;

  assign mode = '{a_signed: a_signed_i, b_signed: b_signed_i, narrow: narrow_i};

  mulx_operand_ext #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) ext_a_i (
    .signed_i(mode.a_signed), .narrow_i(mode.narrow), .op_i(a_i), .ext_o(a_ext));

  mulx_operand_ext #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) ext_b_i (
    .signed_i(mode.b_signed), .narrow_i(mode.narrow), .op_i(b_i), .ext_o(b_ext));

  mulx_array #(.EXT_W(EXT_W), .OUT_W(OUT_W)) array_i (
    .a_i(a_ext), .b_i(b_ext), .prod_o(prod));

  mulx_result_reg #(.OUT_W(OUT_W)) result_i (
    .clk(clk), .rst(rst), .load_i(start_i), .prod_i(prod),
    .product_o(product_o), .valid_o(valid_o));

  // R4
  word_unsigned_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !narrow_i && !a_signed_i && !b_signed_i) |=>
    product_o == ({{DATA_W{1'b0}}, $past(a_i)} * {{DATA_W{1'b0}}, $past(b_i)}));
  // R8
  narrow_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && narrow_i && !a_signed_i && !b_signed_i) |=> product_o[OUT_W-1:HALF_W] == '0);
  // R8
  narrow_sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && narrow_i && (a_signed_i || b_signed_i)) |=>
    product_o[OUT_W-1:HALF_W] == {(OUT_W-HALF_W){product_o[HALF_W-1]}});
endmodule

// File: tb/mulx_core_tb_top.sv
module mulx_core_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic a_signed_i = 1'b0, b_signed_i = 1'b0, narrow_i = 1'b0;
  logic [31:0] product_o;
  logic valid_o;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mulx_core dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .a_i(a_i), .b_i(b_i),
    .a_signed_i(a_signed_i), .b_signed_i(b_signed_i), .narrow_i(narrow_i),
    .product_o(product_o), .valid_o(valid_o));

  function automatic logic [31:0] model(input logic [15:0] a, input logic [15:0] b,
                                        input logic as, input logic bs, input logic n);
    longint va, vb, p;
    va = n ? longint'(a[7:0]) : longint'(a);
    vb = n ? longint'(b[7:0]) : longint'(b);
    if (as && (n ? a[7] : a[15])) va = va - (n ? 256 : 65536);
    if (bs && (n ? b[7] : b[15])) vb = vb - (n ? 256 : 65536);
    p = va * vb;
    return p[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic do_mul(input string req, input logic [15:0] a, input logic [15:0] b,
                        input logic as, input logic bs, input logic n,
                        input logic [31:0] exp);
    logic [31:0] held;
    @(negedge clk);
    a_i = a; b_i = b; a_signed_i = as; b_signed_i = bs; narrow_i = n; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 valid after start", {31'b0, valid_o}, 32'd1);
    check(req, product_o, exp);
    check({req, " model"}, exp, model(a, b, as, bs, n));
    held = product_o;
    a_i = ~a; b_i = a ^ 16'h5A5A; a_signed_i = ~as; narrow_i = ~n;
    @(negedge clk);
    check("R2 valid drops", {31'b0, valid_o}, 32'd0);
    check("R3 hold on idle", product_o, held);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 product in reset", product_o, 32'd0);
    check("R1 valid in reset", {31'b0, valid_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 product after reset", product_o, 32'd0);
    check("R1 valid after reset", {31'b0, valid_o}, 32'd0);
  endtask

  task automatic t_word_unsigned;
    do_mul("R4 ffff*ffff", 16'hFFFF, 16'hFFFF, 0, 0, 0, 32'hFFFE0001);
    do_mul("R4 1234*5678", 16'd1234, 16'd5678, 0, 0, 0, 32'd7006652);
  endtask

  task automatic t_word_signed;
    do_mul("R5 8000*8000", 16'h8000, 16'h8000, 1, 1, 0, 32'h40000000);
    do_mul("R5 -1*-1", 16'hFFFF, 16'hFFFF, 1, 1, 0, 32'h00000001);
    do_mul("R5 -3*7", 16'hFFFD, 16'h0007, 1, 1, 0, 32'hFFFFFFEB);
  endtask

  task automatic t_word_mixed;
    do_mul("R6 s8000*uffff", 16'h8000, 16'hFFFF, 1, 0, 0, 32'h80008000);
    do_mul("R6 uffff*sffff", 16'hFFFF, 16'hFFFF, 0, 1, 0, 32'hFFFF0001);
  endtask

  task automatic t_narrow;
    do_mul("R7 upper bytes ignored", 16'hAB05, 16'hCD07, 0, 0, 1, 32'd35);
    do_mul("R7 upper bytes ignored signed", 16'h7FFE, 16'h80FD, 1, 1, 1, 32'd6);
    do_mul("R8 uff*uff", 16'h00FF, 16'h00FF, 0, 0, 1, 32'h0000FE01);
    do_mul("R8 s80*s80", 16'h0080, 16'h0080, 1, 1, 1, 32'h00004000);
    do_mul("R8 sff*s01", 16'h00FF, 16'h0001, 1, 1, 1, 32'hFFFFFFFF);
    do_mul("R8 s80*uff", 16'h0080, 16'h00FF, 1, 0, 1, 32'hFFFF8080);
  endtask

  task automatic t_sign_position;
    do_mul("R9 byte sign at bit7", 16'h0080, 16'h0001, 1, 0, 1, 32'hFFFFFF80);
    do_mul("R9 word sign at bit15", 16'h0080, 16'h0001, 1, 0, 0, 32'h00000080);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    a_i = 16'd3; b_i = 16'd4; a_signed_i = 0; b_signed_i = 0; narrow_i = 0; start_i = 1'b1;
    @(negedge clk);
    check("R2 first of pair valid", {31'b0, valid_o}, 32'd1);
    check("R2 first of pair product", product_o, 32'd12);
    a_i = 16'hFFFE; b_i = 16'd5; a_signed_i = 1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 second of pair valid", {31'b0, valid_o}, 32'd1);
    check("R2 second of pair product", product_o, 32'hFFFFFFF6);
    @(negedge clk);
    check("R2 pair ends", {31'b0, valid_o}, 32'd0);
    check("R3 pair held", product_o, 32'hFFFFFFF6);
  endtask

  initial begin
    t_reset();
    t_word_unsigned();
    t_word_signed();
    t_word_mixed();
    t_narrow();
    t_sign_position();
    t_back_to_back();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule